// File: doc/BRIEF.md
# Carry-less and GF(2^m) Multiplier

A sequential polynomial multiplier over GF(2). It forms carry-less products of two XLEN-bit operands and multiplies field elements modulo an irreducible polynomial. The degree and the polynomial are runtime inputs. All four operations run on one shift-and-XOR datapath that handles one bit of operand B per clock. The carry-less forms are the field form with reduction switched off.

A caller presents the operands, the operation code, the degree and the polynomial, then raises start for one cycle while the unit is idle. XLEN clocks later done pulses and the result appears. The result stays on the output until the next operation completes.

Top module: `gf2m_mul`

## Requirements
- R1: While reset is asserted and after its release, before any operation, done_o is 0 and result_o is 0.
- R2: With op_i = 0, result_o is the low XLEN bits of the carry-less product: the XOR of (A << i) over every set bit i of B, for i from 0 to XLEN-1.
- R3: With op_i = 1, result_o is the XOR of (A >> (XLEN-i)) over every set bit i of B, for i from 1 to XLEN-1. This is the upper half of the carry-less product.
- R4: With op_i = 2, result_o is the XOR of (A >> (XLEN-1-i)) over every set bit i of B, for i from 0 to XLEN-1. This is product bits 2*XLEN-2 down to XLEN-1.
- R5: With op_i = 3, result_o is A times B in GF(2^m), where m = deg_i (1 to XLEN) and poly_i holds the full modulus including its x^m term at bit m. For example, 7 times 5 with modulus 0b1011 gives 6, and 0x80 times 0x83 with modulus 0x11B gives 0x01. Operands are below 2^m.
- R6: For op_i values 0 to 2, deg_i and poly_i have no effect on the result.
- R7: When start_i is accepted at a rising edge, done_o is 1 during exactly the one cycle that follows the XLEN-th later rising edge.
- R8: start_i is accepted only when no operation is in progress. A start raised while busy is dropped, and its operands do not affect the running operation.
- R9: result_o changes only in the cycle in which done_o is 1 and holds its value until the next completion.
- R10: For any A and B, the results of op 1 and op 0 for that pair, concatenated high then low, equal the full 2*XLEN-bit carry-less product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| op_i | input | 2 | 0 low, 1 high, 2 reversed, 3 field multiply |
| a_i | input | XLEN | Operand A (multiplicand) |
| b_i | input | XLEN | Operand B (multiplier) |
| deg_i | input | $clog2(XLEN+1) | Field degree m, 1..XLEN |
| poly_i | input | XLEN+1 | Modulus including the x^m term |
| result_o | output | XLEN | Result of the last completed operation |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with the default XLEN of 64. At this width a degree of 64 is legal, so the modulus needs its full 65-bit input and the x^64 overflow bit of the shifted operand is exercised. The two small-field examples and a degree-1 field are also reachable. Random 64-bit pairs cover the high and reversed slices of a 128-bit product. A start pulse issued in the middle of an operation checks that it is dropped.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
  typedef enum logic [1:0] {
    OP_LO  = 2'd0,
    OP_HI  = 2'd1,
    OP_REV = 2'd2,
    OP_FLD = 2'd3
  } gf_op_e;
endpackage

// File: rtl/gf2m_ctrl.sv
module gf2m_ctrl #(
  parameter int XLEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o
);
  localparam int CNT_W = $clog2(XLEN);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last   = busy_q && (cnt_q == CNT_W'(XLEN-1));
  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;
  assign fin_o  = last;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (last) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last |=> busy_q);
  // R8
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_q && cnt_q == '0);
endmodule

// File: rtl/gf2m_step.sv
module gf2m_step #(
  parameter int XLEN  = 64,
  parameter int DEG_W = $clog2(XLEN+1)
) (
  input  logic [2*XLEN-1:0] sa_i,
  input  logic [2*XLEN-1:0] acc_i,
  input  logic              bbit_i,
  input  logic              fld_i,
  input  logic [DEG_W-1:0]  deg_i,
  input  logic [XLEN:0]     poly_i,
  output logic [2*XLEN-1:0] sa_o,
  output logic [2*XLEN-1:0] acc_o
);
  logic [2*XLEN-1:0] sh;
  logic [2*XLEN-1:0] poly_ext;

  assign poly_ext = {{(XLEN-1){1'b0}}, poly_i};
  assign sh       = sa_i << 1;

  always_comb begin
    acc_o = bbit_i ? (acc_i ^ sa_i) : acc_i;
    sa_o  = sh;
    // overflow into x^m folds back through the modulus
    if (fld_i && sh[deg_i]) sa_o = sh ^ poly_ext;
  end
endmodule

// File: rtl/gf2m_slice.sv
module gf2m_slice
  import gf2m_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  gf_op_e            op_i,
  input  logic [2*XLEN-1:0] prod_i,
  output logic [XLEN-1:0]   res_o
);
  always_comb begin
    unique case (op_i)
      OP_HI:   res_o = prod_i[2*XLEN-1:XLEN];
      OP_REV:  res_o = prod_i[2*XLEN-2:XLEN-1];
      default: res_o = prod_i[XLEN-1:0];
    endcase
  end
endmodule

// File: rtl/gf2m_mul.sv
module gf2m_mul
  import gf2m_pkg::*;
#(
  parameter  int XLEN  = 64,
  localparam int DEG_W = $clog2(XLEN+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [DEG_W-1:0]  deg_i,
  input  logic [XLEN:0]     poly_i,
  output logic [XLEN-1:0]   result_o,
  output logic              done_o
);
  logic              load, step, fin, busy;
  logic [2*XLEN-1:0] sa_q, acc_q, sa_n, acc_n;
  logic [XLEN-1:0]   b_q, res_n, result_q;
  gf_op_e            op_q;
  logic [DEG_W-1:0]  deg_q;
  logic [XLEN:0]     poly_q;
  logic              done_q;

  gf2m_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fin_o  (fin),
    .busy_o (busy)
  );

  gf2m_step #(.XLEN(XLEN), .DEG_W(DEG_W)) u_step (
    .sa_i  (sa_q),
    .acc_i (acc_q),
    .bbit_i(b_q[0]),
    .fld_i (op_q == OP_FLD),
    .deg_i (deg_q),
    .poly_i(poly_q),
    .sa_o  (sa_n),
    .acc_o (acc_n)
  );

  gf2m_slice #(.XLEN(XLEN)) u_slice (
    .op_i  (op_q),
    .prod_i(acc_n),
    .res_o (res_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_q     <= '0;
      acc_q    <= '0;
      b_q      <= '0;
      op_q     <= OP_LO;
      deg_q    <= '0;
      poly_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin;
      if (load) begin
        sa_q   <= {{XLEN{1'b0}}, a_i};
        acc_q  <= '0;
        b_q    <= b_i;
        op_q   <= gf_op_e'(op_i);
        deg_q  <= deg_i;
        poly_q <= poly_i;
      end else if (step) begin
        sa_q  <= sa_n;
        acc_q <= acc_n;
        b_q   <= b_q >> 1;
      end
      if (fin) result_q <= res_n;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy && $past(busy));
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/gf2m_mul_test.sv
module gf2m_mul_test;
  localparam int XLEN  = 64;
  localparam int DEG_W = $clog2(XLEN+1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        op = '0;
  logic [XLEN-1:0]   a = '0, b = '0;
  logic [DEG_W-1:0]  deg = '0;
  logic [XLEN:0]     poly = '0;
  logic [XLEN-1:0]   result;
  logic              done;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gf2m_mul #(.XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .deg_i(deg), .poly_i(poly),
    .result_o(result), .done_o(done)
  );

  function automatic logic [2*XLEN-1:0] full_prod(logic [XLEN-1:0] x, logic [XLEN-1:0] y);
    logic [2*XLEN-1:0] p = '0;
    for (int i = 0; i < XLEN; i++)
      if (y[i]) p ^= {{XLEN{1'b0}}, x} << i;
    return p;
  endfunction

  function automatic logic [XLEN-1:0] ref_res(logic [1:0] o, logic [XLEN-1:0] x,
      logic [XLEN-1:0] y, int m, logic [XLEN:0] g);
    logic [XLEN-1:0]   r = '0;
    logic [2*XLEN-1:0] p;
    case (o)
      2'd0: for (int i = 0; i < XLEN; i++) if (y[i]) r ^= x << i;
      2'd1: for (int i = 1; i < XLEN; i++) if (y[i]) r ^= x >> (XLEN-i);
      2'd2: for (int i = 0; i < XLEN; i++) if (y[i]) r ^= x >> (XLEN-1-i);
      default: begin
        // long division of the full product by the modulus
        p = full_prod(x, y);
        for (int k = 2*XLEN-2; k >= m; k--)
          if (p[k]) p ^= {{(XLEN-1){1'b0}}, g} << (k-m);
        r = p[XLEN-1:0];
      end
    endcase
    return r;
  endfunction

  function automatic string op_tag(logic [1:0] o);
    case (o)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle model
  bit              m_busy = 0, m_done = 0;
  int              m_cnt = 0;
  logic [XLEN-1:0] m_res = '0, m_a, m_b;
  logic [1:0]      m_op;
  int              m_deg;
  logic [XLEN:0]   m_poly;
  logic [1:0]      last_op = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
    end else begin
      cycles++;
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == XLEN) begin
          m_busy = 0; m_done = 1;
          m_res = ref_res(m_op, m_a, m_b, m_deg, m_poly);
          last_op = m_op;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0;
        m_a = a; m_b = b; m_op = op; m_deg = int'(deg); m_poly = poly;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done === m_done, "R7", {63'b0, done}, {63'b0, m_done});
      chk(result === m_res, m_done ? op_tag(last_op) : "R9", result, m_res);
    end
  end

  int waited;
  task automatic run_op(logic [1:0] o, logic [XLEN-1:0] x, logic [XLEN-1:0] y,
                        int m, logic [XLEN:0] g);
    op = o; a = x; b = y; deg = DEG_W'(m); poly = g; start = 1'b1;
    waited = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      waited++;
    end while (!done && waited < 200);
  endtask

  logic [XLEN-1:0] lo, hi, ra, rb, first;

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R1", {63'b0, done}, '0);
    chk(result === '0, "R1", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result === '0 && done === 1'b0, "R1", result, '0);

    // R5 small fields
    run_op(2'd3, 64'd7, 64'd5, 3, 65'b1011);
    chk(result === 64'd6, "R5", result, 64'd6);
    chk(waited == XLEN + 1, "R7", 64'(waited), 64'(XLEN + 1));
    run_op(2'd3, 64'h80, 64'h83, 8, 65'h11B);
    chk(result === 64'h1, "R5", result, 64'h1);
    run_op(2'd3, 64'd1, 64'd1, 1, 65'b11);
    chk(result === 64'd1, "R5", result, 64'd1);
    ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
    run_op(2'd3, ra, rb, 64, {1'b1, 64'h1B});
    chk(result === ref_res(2'd3, ra, rb, 64, {1'b1, 64'h1B}), "R5", result,
        ref_res(2'd3, ra, rb, 64, {1'b1, 64'h1B}));

    // R2 R3 R4 directed
    run_op(2'd0, 64'd3, 64'd3, 0, '0);
    chk(result === 64'd5, "R2", result, 64'd5);
    run_op(2'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, '0);
    chk(result === 64'h4000_0000_0000_0000, "R3", result, 64'h4000_0000_0000_0000);
    run_op(2'd2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, '0);
    chk(result === 64'h8000_0000_0000_0000, "R4", result, 64'h8000_0000_0000_0000);
    run_op(2'd0, '1, '1, 0, '0);
    chk(result === ref_res(2'd0, '1, '1, 0, '0), "R2", result, ref_res(2'd0, '1, '1, 0, '0));

    // R6 degree and modulus ignored
    run_op(2'd0, 64'hFFFF, 64'h1234_5678, 5, 65'h1_DEAD_BEEF);
    chk(result === ref_res(2'd0, 64'hFFFF, 64'h1234_5678, 0, '0), "R6", result,
        ref_res(2'd0, 64'hFFFF, 64'h1234_5678, 0, '0));
    run_op(2'd2, 64'hF0F0, 64'hFFFF_0000_0000_0001, 3, 65'b1011);
    chk(result === ref_res(2'd2, 64'hF0F0, 64'hFFFF_0000_0000_0001, 0, '0), "R6", result,
        ref_res(2'd2, 64'hF0F0, 64'hFFFF_0000_0000_0001, 0, '0));

    // R8 start while busy is dropped
    op = 2'd0; a = 64'h1234; b = 64'h5; deg = '0; poly = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    op = 2'd1; a = '1; b = '1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waited = 0;
    while (!done && waited < 200) begin @(negedge clk); waited++; end
    first = ref_res(2'd0, 64'h1234, 64'h5, 0, '0);
    chk(result === first, "R8", result, first);
    @(negedge clk);
    chk(done === 1'b0 && result === first, "R9", result, first);

    // R10 random split products
    for (int n = 0; n < 8; n++) begin
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      run_op(2'd0, ra, rb, 0, '0); lo = result;
      run_op(2'd1, ra, rb, 0, '0); hi = result;
      chk({hi, lo} === full_prod(ra, rb), "R10", hi ^ lo,
          full_prod(ra, rb)[XLEN-1:0] ^ full_prod(ra, rb)[2*XLEN-1:XLEN]);
      run_op(2'd2, ra, rb, 0, '0);
      chk(result === full_prod(ra, rb)[2*XLEN-2:XLEN-1], "R4", result,
          full_prod(ra, rb)[2*XLEN-2:XLEN-1]);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule